// File: doc/BRIEF.md
# Execute-Stage Result Bypass Unit

This block sits beside the execute stage of a five-stage pipelined processor and removes read-after-write hazards for results that have not yet reached the register file. At every clock edge it records the execute-stage result together with its destination register number and a valid flag. It keeps that record for two clock periods in a short chain of tag and value registers. The instruction currently in execute therefore sees the results of the two instructions just ahead of it, which the register file cannot yet supply.

For each of the two source operands, the unit compares the source register number against every live tag. It picks the youngest matching result. If no tag matches, it passes the register-file value through. Operand 1 has one more input: when the instruction in execute is a branch, the program-counter copy takes priority over everything else. Operand selection is combinational within the execute cycle. Only the tag, value and valid registers are clocked.

Top module: `rb_bypass_unit`

## Requirements
- R1: When an instruction with the write-enable high sits in execute, its result is returned as the operand of the next instruction whose source register number equals its destination number.
- R2: A written result is still returned one cycle later, for the instruction two places behind, provided no younger valid entry matches.
- R3: A result is no longer forwarded three cycles after it was produced. The operand then falls back to the register-file value.
- R4: While the active-high branch flag is 1, operand 1 equals the program-counter copy, whatever the tags hold.
- R5: When both held entries match source register 1, operand 1 takes the younger (one-cycle-old) result.
- R6: Operand 2 follows the same youngest-first tag priority against source register 2, and the branch flag has no effect on operand 2.
- R7: When no valid entry matches, each operand equals its register-file input.
- R8: An instruction whose write-enable is 0 still advances through the chain, but its entry never matches a source register.
- R9: A synchronous active-high reset clears both valid flags, so no forwarding occurs until new results are captured after reset.
- R10: The operands follow changes of the source numbers, register-file values, PC copy and branch flag within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_result | input | DW | Result produced by the instruction in execute |
| ex_dest | input | RW | Destination register number of that instruction |
| ex_wr_en | input | 1 | 1 when that instruction writes a register |
| src1_idx | input | RW | Source register 1 number of the instruction in execute |
| src2_idx | input | RW | Source register 2 number of the instruction in execute |
| rf_val1 | input | DW | Register-file value for source 1 |
| rf_val2 | input | DW | Register-file value for source 2 |
| pc_copy | input | DW | Program-counter copy carried with the instruction |
| is_branch | input | 1 | 1 when the instruction in execute is a branch |
| op1_out | output | DW | Selected operand 1 |
| op2_out | output | DW | Selected operand 2 |

## Verification
The hardest situation to reach is the one where both held entries carry the same destination number while the younger one is invalid, or where both are valid. Priority and the write-enable gating then interact. The stimulus gives consecutive instructions equal destination numbers in pairs and drops the write-enable on every fifth instruction. It also rotates the source numbers so they point at the destinations one, two and three instructions back. Every combination of age, validity and duplicated tag therefore recurs many times, and this includes the cycles just after a mid-run reset.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int unsigned RB_DATA_W  = 32;
    localparam int unsigned RB_REG_W   = 4;
    localparam int unsigned RB_DEPTH   = 2;

    typedef enum logic [1:0] {
        PICK_RF   = 2'd0,
        PICK_FWD  = 2'd1,
        PICK_PC   = 2'd2
    } pick_kind_e;

endpackage

// File: rtl/rb_tag_match.sv
module rb_tag_match #(
    parameter int unsigned RW = 4
) (
    input  logic [RW-1:0] tag_a,
    input  logic [RW-1:0] tag_b,
    input  logic          tag_vld,
    output logic          hit
);
    logic [RW-1:0] bit_eq;

    // per-bit equality, then a wide AND
    for (genvar gi = 0; gi < RW; gi++) begin : g_bit
        assign bit_eq[gi] = ~(tag_a[gi] ^ tag_b[gi]);
    end

    assign hit = tag_vld & (&bit_eq);

endmodule

// File: rtl/rb_fwd_chain.sv
module rb_fwd_chain #(
    parameter int unsigned DW    = 32,
    parameter int unsigned RW    = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DW-1:0]                  in_val,
    input  logic [RW-1:0]                  in_tag,
    input  logic                           in_vld,
    output logic [DEPTH-1:0]               ent_vld,
    output logic [DEPTH-1:0][RW-1:0]       ent_tag,
    output logic [DEPTH-1:0][DW-1:0]       ent_val
);
    typedef struct packed {
        logic          vld;
        logic [RW-1:0] tag;
        logic [DW-1:0] val;
    } ent_t;

    ent_t [DEPTH-1:0] ent_d;
    ent_t [DEPTH-1:0] ent_q;

    // next-state: entry 0 takes the execute result, others shift one place
    always_comb begin
        ent_d[0].vld = in_vld;
        ent_d[0].tag = in_tag;
        ent_d[0].val = in_val;
        for (int i = 1; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].vld <= 1'b0;
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_out
        assign ent_vld[gi] = ent_q[gi].vld;
        assign ent_tag[gi] = ent_q[gi].tag;
        assign ent_val[gi] = ent_q[gi].val;
    end

endmodule

// File: rtl/rb_operand_pick.sv
module rb_operand_pick
    import rb_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned RW     = 4,
    parameter int unsigned DEPTH  = 2,
    parameter bit          USE_PC = 1'b1
) (
    input  logic [RW-1:0]              src_idx,
    input  logic [DW-1:0]              rf_val,
    input  logic [DW-1:0]              pc_val,
    input  logic                       is_branch,
    input  logic [DEPTH-1:0]           ent_vld,
    input  logic [DEPTH-1:0][RW-1:0]   ent_tag,
    input  logic [DEPTH-1:0][DW-1:0]   ent_val,
    output logic [DW-1:0]              opnd
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] hit;
    logic             pc_take;
    pick_kind_e       kind;
    logic [IDX_W-1:0] fwd_idx;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
        rb_tag_match #(.RW(RW)) cmp_i (
            .tag_a   (ent_tag[gi]),
            .tag_b   (src_idx),
            .tag_vld (ent_vld[gi]),
            .hit     (hit[gi])
        );
    end

    if (USE_PC) begin : g_pc
        assign pc_take = is_branch;
    end else begin : g_nopc
        logic unused_pc;
        assign unused_pc = is_branch ^ (|pc_val);
        assign pc_take   = 1'b0;
    end

    // priority: PC (if enabled), youngest hit, ..., register file
    always_comb begin
        kind    = PICK_RF;
        fwd_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                kind    = PICK_FWD;
                fwd_idx = IDX_W'(i);
            end
        end
        if (pc_take) begin
            kind = PICK_PC;
        end
    end

    always_comb begin
        unique case (kind)
            PICK_PC:  opnd = pc_val;
            PICK_FWD: opnd = ent_val[fwd_idx];
            default:  opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/rb_bypass_unit.sv
module rb_bypass_unit
    import rb_pkg::*;
#(
    parameter int unsigned DW    = RB_DATA_W,
    parameter int unsigned RW    = RB_REG_W,
    parameter int unsigned DEPTH = RB_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ex_result,
    input  logic [RW-1:0] ex_dest,
    input  logic          ex_wr_en,
    input  logic [RW-1:0] src1_idx,
    input  logic [RW-1:0] src2_idx,
    input  logic [DW-1:0] rf_val1,
    input  logic [DW-1:0] rf_val2,
    input  logic [DW-1:0] pc_copy,
    input  logic          is_branch,
    output logic [DW-1:0] op1_out,
    output logic [DW-1:0] op2_out
);
    logic [DEPTH-1:0]         ent_vld;
    logic [DEPTH-1:0][RW-1:0] ent_tag;
    logic [DEPTH-1:0][DW-1:0] ent_val;

    rb_fwd_chain #(.DW(DW), .RW(RW), .DEPTH(DEPTH)) chain_i (
        .clk     (clk),
        .rst     (rst),
        .in_val  (ex_result),
        .in_tag  (ex_dest),
        .in_vld  (ex_wr_en),
        .ent_vld (ent_vld),
        .ent_tag (ent_tag),
        .ent_val (ent_val)
    );

    rb_operand_pick #(.DW(DW), .RW(RW), .DEPTH(DEPTH), .USE_PC(1'b1)) pick1_i (
        .src_idx   (src1_idx),
        .rf_val    (rf_val1),
        .pc_val    (pc_copy),
        .is_branch (is_branch),
        .ent_vld   (ent_vld),
        .ent_tag   (ent_tag),
        .ent_val   (ent_val),
        .opnd      (op1_out)
    );

    rb_operand_pick #(.DW(DW), .RW(RW), .DEPTH(DEPTH), .USE_PC(1'b0)) pick2_i (
        .src_idx   (src2_idx),
        .rf_val    (rf_val2),
        .pc_val    (pc_copy),
        .is_branch (is_branch),
        .ent_vld   (ent_vld),
        .ent_tag   (ent_tag),
        .ent_val   (ent_val),
        .opnd      (op2_out)
    );

endmodule

// File: rtl/rb_bypass_chk.sv
module rb_bypass_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned RW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] ex_result,
    input logic [RW-1:0] ex_dest,
    input logic          ex_wr_en,
    input logic [RW-1:0] src1_idx,
    input logic [RW-1:0] src2_idx,
    input logic [DW-1:0] rf_val1,
    input logic [DW-1:0] rf_val2,
    input logic [DW-1:0] pc_copy,
    input logic          is_branch,
    input logic [DW-1:0] op1_out,
    input logic [DW-1:0] op2_out
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R4
    r4_branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        is_branch |-> (op1_out == pc_copy));

    // R1
    r1_near_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && !is_branch && $past(ex_wr_en) && src1_idx == $past(ex_dest))
        |-> (op1_out == $past(ex_result)));

    // R2
    r2_far_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && $past(ex_wr_en, 2) && src2_idx == $past(ex_dest, 2)
         && !($past(ex_wr_en) && src2_idx == $past(ex_dest)))
        |-> (op2_out == $past(ex_result, 2)));

    // R7
    r7_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2
         && !($past(ex_wr_en) && src2_idx == $past(ex_dest))
         && !($past(ex_wr_en, 2) && src2_idx == $past(ex_dest, 2)))
        |-> (op2_out == rf_val2));

    // R9
    r9_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd0) |-> (op2_out == rf_val2 && (is_branch || op1_out == rf_val1)));

endmodule

bind rb_bypass_unit rb_bypass_chk #(.DW(DW), .RW(RW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ex_result (ex_result),
    .ex_dest   (ex_dest),
    .ex_wr_en  (ex_wr_en),
    .src1_idx  (src1_idx),
    .src2_idx  (src2_idx),
    .rf_val1   (rf_val1),
    .rf_val2   (rf_val2),
    .pc_copy   (pc_copy),
    .is_branch (is_branch),
    .op1_out   (op1_out),
    .op2_out   (op2_out)
);

// File: tb/rb_bypass_unit_tb_top.sv
module rb_bypass_unit_tb_top;
    localparam int DW = 32;
    localparam int RW = 4;

    logic          clk;
    logic          rst;
    logic [DW-1:0] ex_result;
    logic [RW-1:0] ex_dest;
    logic          ex_wr_en;
    logic [RW-1:0] src1_idx;
    logic [RW-1:0] src2_idx;
    logic [DW-1:0] rf_val1;
    logic [DW-1:0] rf_val2;
    logic [DW-1:0] pc_copy;
    logic          is_branch;
    logic [DW-1:0] op1_out;
    logic [DW-1:0] op2_out;

    int checks;
    int fails;
    bit done;

    rb_bypass_unit #(.DW(DW), .RW(RW)) dut_i (
        .clk(clk), .rst(rst), .ex_result(ex_result), .ex_dest(ex_dest),
        .ex_wr_en(ex_wr_en), .src1_idx(src1_idx), .src2_idx(src2_idx),
        .rf_val1(rf_val1), .rf_val2(rf_val2), .pc_copy(pc_copy),
        .is_branch(is_branch), .op1_out(op1_out), .op2_out(op2_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // reference history: index 0 = one instruction back, 2 = three back
    logic          m_v [3];
    logic [RW-1:0] m_t [3];
    logic [DW-1:0] m_d [3];
    int            since_rst;

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_v[i] = 1'b0; m_t[i] = '0; m_d[i] = '0;
        end
        since_rst = 0;
    end

    always @(posedge clk) begin
        m_v[2] <= m_v[1]; m_t[2] <= m_t[1]; m_d[2] <= m_d[1];
        m_v[1] <= m_v[0]; m_t[1] <= m_t[0]; m_d[1] <= m_d[0];
        m_v[0] <= ex_wr_en; m_t[0] <= ex_dest; m_d[0] <= ex_result;
        since_rst <= since_rst + 1;
        if (rst) begin
            m_v[0] <= 1'b0; m_v[1] <= 1'b0; m_v[2] <= 1'b0;
            since_rst <= 0;
        end
    end

    function automatic logic [DW-1:0] expect_op(input logic [RW-1:0] s,
                                                input logic [DW-1:0] rf,
                                                input logic use_pc);
        if (use_pc && is_branch)            return pc_copy;
        if (m_v[0] && m_t[0] == s)          return m_d[0];
        if (m_v[1] && m_t[1] == s)          return m_d[1];
        return rf;
    endfunction

    function automatic string classify(input logic [RW-1:0] s, input logic is_op1);
        if (is_op1 && is_branch)                          return "R4";
        if (!is_op1 && is_branch)                         return "R6";
        if (m_v[0] && m_t[0] == s && m_v[1] && m_t[1] == s) return is_op1 ? "R5" : "R6";
        if (m_v[0] && m_t[0] == s)                        return "R1";
        if (m_v[1] && m_t[1] == s)                        return "R2";
        if (since_rst < 2)                                return "R9";
        if ((m_t[0] == s && !m_v[0]) || (m_t[1] == s && !m_v[1])) return "R8";
        if (m_v[2] && m_t[2] == s)                        return "R3";
        return "R7";
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [RW-1:0] dest_of(input int k);
        return RW'(((k >>> 1) * 5) & 15);
    endfunction

    function automatic logic [RW-1:0] src_pick(input int k, input int phase);
        case ((k + phase) % 4)
            0: return dest_of(k - 1);
            1: return dest_of(k - 2);
            2: return dest_of(k - 3);
            default: return RW'(k & 15);
        endcase
    endfunction

    initial begin
        checks = 0; fails = 0; done = 1'b0;
        rst = 1'b1; ex_result = '0; ex_dest = '0; ex_wr_en = 1'b1;
        src1_idx = '0; src2_idx = '0; rf_val1 = 32'h1234_0001;
        rf_val2 = 32'h1234_0002; pc_copy = 32'h0000_4000; is_branch = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state: valid flags cleared, register-file values pass through (R9)
        check(op1_out, rf_val1, "R9");
        check(op2_out, rf_val2, "R9");

        for (int k = 0; k < 768; k++) begin
            @(negedge clk);
            rst       = (k == 400);
            ex_dest   = dest_of(k);
            ex_wr_en  = (k % 5) != 4;
            ex_result = 32'hA500_0000 ^ (k * 32'h0001_0203);
            is_branch = (k % 7) == 3;
            pc_copy   = 32'h0000_8000 + k * 4;
            rf_val1   = 32'h1111_0000 + k;
            rf_val2   = 32'h2222_0000 + k;
            src1_idx  = src_pick(k, 0);
            src2_idx  = src_pick(k, 1);
            #1;
            check(op1_out, expect_op(src1_idx, rf_val1, 1'b1), classify(src1_idx, 1'b1));
            check(op2_out, expect_op(src2_idx, rf_val2, 1'b0), classify(src2_idx, 1'b0));
            // same-cycle change of selection inputs (R10)
            src1_idx  = src_pick(k, 2);
            rf_val1   = ~rf_val1;
            is_branch = ~is_branch;
            #1;
            check(op1_out, expect_op(src1_idx, rf_val1, 1'b1), "R10");
        end

        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule